// File: doc/BRIEF.md
# Memory-Mapped Identification and Scratch Register Block

This block is a small control/status register file behind an Avalon-MM slave port. It holds two 32-bit words: a read-only identification word that carries a module ID and a revision, and a read-write scratch word. A bus master uses the identification word to find out which module and which revision sits at the base address. It uses the scratch word to test that writes and reads work.

A read samples the address on the same clock edge as the read strobe. The master therefore only has to hold the address during the one cycle in which read is high. It may change the address, or drive any value, from the next cycle on. Read data comes back exactly one clock later, marked by a single-cycle valid pulse. Writes complete on the edge where the strobe is sampled. The wait signal never stalls the master.

Top module: `csr_regfile_amm`

## Requirements
- R1: After the asynchronous active-low reset, the read-valid output is 0, read data is 0, and the scratch word reads back as 0x00000000.
- R2: A read of offset 0x00 returns 0x00000101: module ID 0 in bits 31:16, major revision 1 in bits 15:8, minor revision 1 in bit 0, and all other bits 0.
- R3: A write to offset 0x04 stores all 32 data bits on that clock edge, and a later read of 0x04 returns them.
- R4: Read data depends only on the address present in the cycle where read is high; the address value in any later cycle has no effect.
- R5: A read of any unmapped offset, meaning an index other than 0 or 1, returns 0.
- R6: Writes to offset 0x00 or to unmapped offsets are ignored: afterwards the identification word still reads 0x00000101 and the scratch word keeps its value.
- R7: Address bits 1:0 are ignored. Addresses 0x0000 to 0x0003 select the identification word, and 0x0004 to 0x0007 select the scratch word.
- R8: When read and write to the scratch word are high in the same cycle, the write takes effect and the read returns the value from before the write.
- R9: Read-valid is high exactly in the cycle after each cycle with read high, and low otherwise. Read data is 0 whenever read-valid is low. Back-to-back reads give back-to-back responses.
- R10: The wait-request output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Byte address; bits 15:2 select the word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after read |
| bus_wait | output | 1 | Wait request, held at 0 |

## Verification
Every read response is due exactly one clock after the edge that samples the read strobe. The driver records that due cycle with the expected word in a queue. The monitor samples outputs on the falling edge and flags a response that is early, late, missing or wrong. A write is due on its own edge, so the driver can issue a read in the very next cycle and expect the new value. Between transfers the driver puts an unmapped address on the bus, so a design that looked at the address one cycle late would return 0 and be caught.

// File: rtl/csr_regfile_pkg.sv
package csr_regfile_pkg;

    // Which register a decoded bus address selects.
    typedef enum logic [1:0] {
        SEL_IDENT   = 2'd0,
        SEL_SCRATCH = 2'd1,
        SEL_NONE    = 2'd2
    } reg_sel_e;

    // Number of word slots the block decodes.
    localparam int unsigned NUM_SLOTS = 2;

    // Pack the identification fields; unbacked bits read as zero.
    function automatic logic [31:0] pack_ident(
        input logic [15:0] mod_id,
        input logic [7:0]  rev_major,
        input logic        rev_minor
    );
        return {mod_id, rev_major, 7'd0, rev_minor};
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_regfile_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int unsigned BYTE_SHIFT = $clog2(DATA_W / 8);
    localparam int unsigned IDX_W      = ADDR_W - BYTE_SHIFT;

    logic [IDX_W-1:0]     word_idx;
    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 unused_low_bits;

    assign word_idx        = addr[ADDR_W-1:BYTE_SHIFT];
    assign unused_low_bits = ^addr[BYTE_SHIFT-1:0];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_hit[s] = (word_idx == IDX_W'(s));
    end

    always_comb begin
        sel = SEL_NONE;
        if (slot_hit[0]) begin
            sel = SEL_IDENT;
        end else if (slot_hit[1]) begin
            sel = SEL_SCRATCH;
        end
    end

    // R7: at most one slot decodes for any address.
    always_comb begin
        a_r7_one_slot: assert ($onehot0(slot_hit));
    end

endmodule

// File: rtl/csr_scratch_reg.sv
module csr_scratch_reg
    import csr_regfile_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } scratch_t;

    scratch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && (sel == SEL_SCRATCH)) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.word;

    // R3: a decoded write lands on its own edge.
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_SCRATCH) |=> (value == $past(wdata)));

    // R6: without a decoded write the word is unchanged.
    a_r6_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == SEL_SCRATCH) |=> $stable(value));

endmodule

// File: rtl/csr_read_resp.sv
module csr_read_resp
    import csr_regfile_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] ident,
    input  logic [DATA_W-1:0] scratch,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } resp_t;

    resp_t st_d, st_q;

    // Address and strobe are consumed on the same edge.
    always_comb begin
        st_d      = '0;
        st_d.vld  = rd;
        if (rd) begin
            unique case (sel)
                SEL_IDENT:   st_d.data = ident;
                SEL_SCRATCH: st_d.data = scratch;
                default:     st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.data;
    assign rvalid = st_q.vld;

    // R9: one response per read strobe, one cycle later.
    a_r9_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);
    a_r9_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    // R5: unmapped reads return zero.
    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> (rdata == '0));

    // R8: a scratch read reports the word held before that edge.
    a_r8_read_sees_old: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_SCRATCH) |=> (rdata == $past(scratch)));

endmodule

// File: rtl/csr_regfile_amm.sv
module csr_regfile_amm
    import csr_regfile_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter logic [15:0] MOD_ID    = 16'h0000,
    parameter logic [7:0]  REV_MAJOR = 8'h01,
    parameter logic        REV_MINOR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_wait
);
    localparam logic [DATA_W-1:0] IDENT_WORD =
        DATA_W'(pack_ident(MOD_ID, REV_MAJOR, REV_MINOR));

    reg_sel_e          sel;
    logic [DATA_W-1:0] scratch_q;

    csr_addr_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    csr_scratch_reg #(
        .DATA_W (DATA_W)
    ) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .value (scratch_q)
    );

    csr_read_resp #(
        .DATA_W (DATA_W)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .sel     (sel),
        .ident   (IDENT_WORD),
        .scratch (scratch_q),
        .rdata   (bus_rdata),
        .rvalid  (bus_rvalid)
    );

    assign bus_wait = 1'b0;

    // R2: an identification read always returns the fixed word.
    a_r2_ident_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_IDENT) |=> (bus_rdata == IDENT_WORD));

endmodule

// File: tb/csr_regfile_amm_test.sv
module csr_regfile_amm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        bus_wait;

    localparam logic [15:0] JUNK_ADDR = 16'hBEEC;  // decodes as unmapped
    localparam logic [31:0] IDENT     = 32'h0000_0101;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cyc      = 0;
    bit          done     = 1'b0;

    typedef struct {
        logic [31:0] data;
        int unsigned due;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    csr_regfile_amm uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .bus_wait   (bus_wait)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One bus cycle; the address is replaced by junk right after.
    task automatic xfer(input bit rd, input bit wr, input logic [15:0] addr,
                        input logic [31:0] wdata, input logic [31:0] exp, input string tag);
        bus_addr  = addr;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_wdata = wdata;
        if (rd) exp_q.push_back('{data: exp, due: cyc + 1, tag: tag});
        @(negedge clk);
        bus_addr  = JUNK_ADDR;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = 32'hDEAD_BEEF;
    endtask

    task automatic rd_word(input logic [15:0] addr, input logic [31:0] exp, input string tag);
        xfer(1'b1, 1'b0, addr, 32'h0, exp, tag);
    endtask

    task automatic wr_word(input logic [15:0] addr, input logic [31:0] data);
        xfer(1'b0, 1'b1, addr, data, 32'h0, "");
    endtask

    // Monitor: compares responses against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 wait low", {31'd0, bus_wait}, 32'd0);
            if (bus_rvalid) begin
                if (exp_q.size() == 0 || exp_q[0].due != cyc) begin
                    check("R9 unexpected valid", 32'd1, 32'd0);
                end else begin
                    check(exp_q[0].tag, bus_rdata, exp_q[0].data);
                    void'(exp_q.pop_front());
                end
            end else begin
                check("R9 idle data zero", bus_rdata, 32'd0);
                if (exp_q.size() != 0 && exp_q[0].due <= cyc) begin
                    check({exp_q[0].tag, " missing valid"}, 32'd0, 32'd1);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rvalid", {31'd0, bus_rvalid}, 32'd0);
        check("R1 reset rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        rd_word(16'h0004, 32'h0, "R1 scratch after reset");
        rd_word(16'h0000, IDENT, "R2 ident read");

        wr_word(16'h0004, 32'hA5A5_5A5A);
        rd_word(16'h0004, 32'hA5A5_5A5A, "R3 scratch readback");
        wr_word(16'h0004, 32'hFFFF_FFFF);
        rd_word(16'h0004, 32'hFFFF_FFFF, "R3 all ones");

        // R4: single-cycle address, junk elsewhere, with idle gaps
        rd_word(16'h0000, IDENT, "R4 ident one-cycle addr");
        repeat (2) @(negedge clk);
        rd_word(16'h0004, 32'hFFFF_FFFF, "R4 scratch one-cycle addr");

        rd_word(16'h0008, 32'h0, "R5 unmapped 0x08");
        rd_word(16'h4004, 32'h0, "R5 unmapped 0x4004");
        rd_word(16'hFFFC, 32'h0, "R5 unmapped 0xFFFC");

        wr_word(16'h0000, 32'h1234_5678);
        wr_word(16'h0008, 32'h1111_2222);
        wr_word(16'h4004, 32'h3333_4444);
        rd_word(16'h0000, IDENT, "R6 ident after write");
        rd_word(16'h0004, 32'hFFFF_FFFF, "R6 scratch kept");
        rd_word(16'h0008, 32'h0, "R6 unmapped still zero");

        wr_word(16'h0006, 32'h0BAD_F00D);
        rd_word(16'h0007, 32'h0BAD_F00D, "R7 low bits on scratch");
        rd_word(16'h0003, IDENT, "R7 low bits on ident");

        xfer(1'b1, 1'b1, 16'h0004, 32'hC0DE_0001, 32'h0BAD_F00D, "R8 read old on rd+wr");
        rd_word(16'h0004, 32'hC0DE_0001, "R8 new value after");

        // R9: back-to-back reads
        rd_word(16'h0000, IDENT, "R9 b2b 0");
        rd_word(16'h0004, 32'hC0DE_0001, "R9 b2b 1");
        rd_word(16'h000C, 32'h0, "R9 b2b 2");
        rd_word(16'h0005, 32'hC0DE_0001, "R9 b2b 3");

        repeat (4) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule